// File: doc/BRIEF.md
# Long-Mode Segment Register Load Checker

This block judges one request to write a segment register while the core runs in 64-bit mode. The request arrives in a single cycle and carries the following:

- the destination register and whether it came from a move or a pop;
- whether a lock prefix was present;
- the 16-bit selector and the current privilege level;
- the limits of the global and local descriptor tables;
- the access fields of the descriptor, which a separate unit has already fetched.

One clock later the block returns exactly one outcome. It either grants the write of the visible selector and hidden descriptor, or it reports a fault with its vector number and error code.

The surrounding pipeline uses the grant to commit the register update. On a fault it hands the vector and error code to the exception logic. Descriptor fetch, far transfers and gates are handled elsewhere. All checks apply a fixed priority: invalid-opcode causes first, then the null-selector rules, then the descriptor-table bound, then type and privilege, and last the present bit.

Top module: `lm_sreg_load_chk`

## Requirements
- R1: Every cycle with `req_valid` high produces, on the next cycle, `rsp_valid` high with exactly one of `rsp_load` and `rsp_fault` set. A cycle without a request gives `rsp_valid`, `rsp_load` and `rsp_fault` low on the next cycle.
- R2: Register codes are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS and 5=GS. A request faults with vector 6 (invalid opcode) and error code 0 when any of these holds: the lock flag is set; the target is CS; the code is 6 or 7; or the kind is pop (`req_pop`=1) with target ES, SS or DS.
- R3: A selector is null when its bits 15..2 are all zero, so the values 0x0000 to 0x0003 all count as null. A null selector loaded into ES, DS, FS or GS is granted with no fault.
- R4: A null selector into SS faults with vector 13 (general protection) and error code 0 when the privilege level is 3, or when the selector RPL (bits 1..0) differs from the privilege level. Otherwise it is granted.
- R5: For a non-null selector, bit 2 picks the table: 0 is global and 1 is local. The request faults with vector 13 when `{sel[15:3],3'b111}` exceeds that table's limit.
- R6: SS requires a segment descriptor (S=1) that is data (type bit 3 = 0) and writable (type bit 1 = 1). Both RPL and DPL must equal the privilege level. Any violation faults with vector 13.
- R7: ES, DS, FS and GS require S=1 and either data or readable code (type bit 3 = 1 with bit 1 = 1), else the request faults with vector 13. Code is conforming when type bits 3 and 2 are both set. For any segment that is not conforming code, the request faults with vector 13 when both RPL and the privilege level exceed DPL.
- R8: A descriptor that is not present (P=0) gives vector 12 (stack fault) for SS and vector 11 (not present) for FS or GS. For ES or DS it is granted.
- R9: When several causes apply, only the first in the order of R2, R4, R5, then R6/R7, then R8 is reported.
- R10: Faults from R5 to R8 carry the selector with bits 1..0 cleared as the error code. Faults from R2 and R4 carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_seg | input | 3 | Destination register code (R2) |
| req_pop | input | 1 | 1 = pop form, 0 = move form |
| req_lock | input | 1 | Lock prefix present |
| req_sel | input | 16 | Selector value |
| req_cpl | input | 2 | Current privilege level |
| gdt_limit | input | LIMIT_W | Global table limit in bytes |
| ldt_limit | input | LIMIT_W | Local table limit in bytes |
| desc_s | input | 1 | Descriptor S bit (1 = code/data) |
| desc_type | input | 4 | Descriptor type field |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| rsp_valid | output | 1 | Verdict valid |
| rsp_load | output | 1 | Grant selector and descriptor write |
| rsp_fault | output | 1 | Fault reported |
| rsp_vector | output | 8 | Fault vector number |
| rsp_errcode | output | 16 | Fault error code |

## Verification
Each verdict depends only on the request of the previous cycle, so any wrong internal decision shows up at the ports exactly one cycle after the request that caused it. A bad priority choice or rule appears as a wrong vector, a wrong grant or a wrong error code. A corrupted selector decode shows up mostly as wrong error codes or spurious table-bound faults. Random requests are biased toward null selectors, tiny indices and small limits, so that the competing causes overlap often. Directed requests pin each priority boundary.

// File: rtl/lmseg_pkg.sv
package lmseg_pkg;
    localparam int SEL_W = 16;

    localparam logic [2:0] SEG_ES = 3'd0;
    localparam logic [2:0] SEG_CS = 3'd1;
    localparam logic [2:0] SEG_SS = 3'd2;
    localparam logic [2:0] SEG_DS = 3'd3;
    localparam logic [2:0] SEG_FS = 3'd4;
    localparam logic [2:0] SEG_GS = 3'd5;

    localparam logic [7:0] VEC_UD = 8'd6;
    localparam logic [7:0] VEC_NP = 8'd11;
    localparam logic [7:0] VEC_SS = 8'd12;
    localparam logic [7:0] VEC_GP = 8'd13;

    typedef struct packed {
        logic             valid;
        logic             load;
        logic             fault;
        logic [7:0]       vector;
        logic [SEL_W-1:0] errcode;
    } verdict_t;
endpackage

// File: rtl/lmseg_sel_decode.sv
module lmseg_sel_decode
    import lmseg_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [LIMIT_W-1:0] gdt_limit,
    input  logic [LIMIT_W-1:0] ldt_limit,
    output logic               is_null,
    output logic [1:0]         rpl,
    output logic               over_limit,
    output logic [SEL_W-1:0]   err_code
);
    localparam int CMP_W = (LIMIT_W > SEL_W) ? LIMIT_W : SEL_W;

    logic [SEL_W-1:0]   last_byte;
    logic [LIMIT_W-1:0] chosen_limit;

    always_comb begin
        is_null      = (sel[SEL_W-1:2] == '0);
        rpl          = sel[1:0];
        last_byte    = {sel[SEL_W-1:3], 3'b111};
        chosen_limit = sel[2] ? ldt_limit : gdt_limit;
        over_limit   = CMP_W'(last_byte) > CMP_W'(chosen_limit);
        err_code     = {sel[SEL_W-1:2], 2'b00};
    end
endmodule

// File: rtl/lmseg_rights.sv
module lmseg_rights
    import lmseg_pkg::*;
#(
    parameter bit CHECK_DSES_PRESENT = 1'b0
) (
    input  logic       is_ss,
    input  logic       is_fsgs,
    input  logic       is_dses,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  logic       s_bit,
    input  logic [3:0] typ,
    input  logic [1:0] dpl,
    input  logic       present,
    output logic       rights_fault,
    output logic       present_fault,
    output logic [7:0] present_vec
);
    logic is_code, rw_bit, conforming;
    logic ss_ok, data_type_ok, priv_bad;
    logic dses_np;

    always_comb begin
        is_code      = typ[3];
        rw_bit       = typ[1];
        conforming   = is_code && typ[2];
        ss_ok        = s_bit && !is_code && rw_bit && (rpl == cpl) && (dpl == cpl);
        data_type_ok = s_bit && (!is_code || rw_bit);
        priv_bad     = !conforming && (rpl > dpl) && (cpl > dpl);
        rights_fault = is_ss ? !ss_ok : (!data_type_ok || priv_bad);
    end

    generate
        if (CHECK_DSES_PRESENT) begin : g_dses_chk
            assign dses_np = is_dses && !present;
        end else begin : g_dses_skip
            assign dses_np = 1'b0;
        end
    endgenerate

    always_comb begin
        present_fault = !present && (is_ss || is_fsgs);
        present_vec   = is_ss ? VEC_SS : VEC_NP;
        if (dses_np) begin
            present_fault = 1'b1;
            present_vec   = VEC_NP;
        end
    end
endmodule

// File: rtl/lm_sreg_load_chk.sv
module lm_sreg_load_chk
    import lmseg_pkg::*;
#(
    parameter int LIMIT_W            = 16,
    parameter bit CHECK_DSES_PRESENT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_seg,
    input  logic               req_pop,
    input  logic               req_lock,
    input  logic [15:0]        req_sel,
    input  logic [1:0]         req_cpl,
    input  logic [LIMIT_W-1:0] gdt_limit,
    input  logic [LIMIT_W-1:0] ldt_limit,
    input  logic               desc_s,
    input  logic [3:0]         desc_type,
    input  logic [1:0]         desc_dpl,
    input  logic               desc_present,
    output logic               rsp_valid,
    output logic               rsp_load,
    output logic               rsp_fault,
    output logic [7:0]         rsp_vector,
    output logic [15:0]        rsp_errcode
);
    logic             is_null, over_limit;
    logic [1:0]       rpl;
    logic [SEL_W-1:0] sel_err;
    logic             is_ss, is_fsgs, is_dses, is_ud;
    logic             rights_fault, present_fault;
    logic [7:0]       present_vec;
    verdict_t         verdict_d, verdict_q;

    lmseg_sel_decode #(.LIMIT_W(LIMIT_W)) u_decode (
        .sel        (req_sel),
        .gdt_limit  (gdt_limit),
        .ldt_limit  (ldt_limit),
        .is_null    (is_null),
        .rpl        (rpl),
        .over_limit (over_limit),
        .err_code   (sel_err)
    );

    lmseg_rights #(.CHECK_DSES_PRESENT(CHECK_DSES_PRESENT)) u_rights (
        .is_ss         (is_ss),
        .is_fsgs       (is_fsgs),
        .is_dses       (is_dses),
        .cpl           (req_cpl),
        .rpl           (rpl),
        .s_bit         (desc_s),
        .typ           (desc_type),
        .dpl           (desc_dpl),
        .present       (desc_present),
        .rights_fault  (rights_fault),
        .present_fault (present_fault),
        .present_vec   (present_vec)
    );

    always_comb begin
        is_ss   = (req_seg == SEG_SS);
        is_fsgs = (req_seg == SEG_FS) || (req_seg == SEG_GS);
        is_dses = (req_seg == SEG_DS) || (req_seg == SEG_ES);
        is_ud   = req_lock || (req_seg == SEG_CS) || (req_seg > SEG_GS) ||
                  (req_pop && (is_ss || is_dses));
    end

    always_comb begin
        verdict_d = '0;
        if (req_valid) begin
            verdict_d.valid = 1'b1;
            if (is_ud) begin
                verdict_d.fault  = 1'b1;
                verdict_d.vector = VEC_UD;
            end else if (is_null) begin
                if (is_ss && ((req_cpl == 2'd3) || (rpl != req_cpl))) begin
                    verdict_d.fault  = 1'b1;
                    verdict_d.vector = VEC_GP;
                end else begin
                    verdict_d.load = 1'b1;
                end
            end else if (over_limit || rights_fault) begin
                verdict_d.fault   = 1'b1;
                verdict_d.vector  = VEC_GP;
                verdict_d.errcode = sel_err;
            end else if (present_fault) begin
                verdict_d.fault   = 1'b1;
                verdict_d.vector  = present_vec;
                verdict_d.errcode = sel_err;
            end else begin
                verdict_d.load = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    assign rsp_valid   = verdict_q.valid;
    assign rsp_load    = verdict_q.load;
    assign rsp_fault   = verdict_q.fault;
    assign rsp_vector  = verdict_q.vector;
    assign rsp_errcode = verdict_q.errcode;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid && !rsp_load && !rsp_fault); // R1
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_load ^ rsp_fault)); // R1
    AST_LOCK_UD: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_lock) |=> (rsp_fault && rsp_vector == VEC_UD && rsp_errcode == '0)); // R2
    AST_CS_NEVER_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_seg == SEG_CS) |=> !rsp_load); // R2
    AST_NULL_DATA_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_lock && !req_pop && (req_seg == SEG_DS || req_seg == SEG_ES) && req_sel[15:2] == '0) |=> rsp_load); // R3
    AST_ERR_RPL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> (rsp_errcode[1:0] == 2'b00)); // R10
    AST_SS_NEVER_NP: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_seg == SEG_SS) |=> !(rsp_fault && rsp_vector == VEC_NP)); // R8
endmodule

// File: tb/lm_sreg_load_chk_tb.sv
module lm_sreg_load_chk_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic        req_pop = 1'b0;
    logic        req_lock = 1'b0;
    logic [15:0] req_sel = '0;
    logic [1:0]  req_cpl = '0;
    logic [15:0] gdt_limit = '0;
    logic [15:0] ldt_limit = '0;
    logic        desc_s = 1'b0;
    logic [3:0]  desc_type = '0;
    logic [1:0]  desc_dpl = '0;
    logic        desc_present = 1'b0;
    logic        rsp_valid, rsp_load, rsp_fault;
    logic [7:0]  rsp_vector;
    logic [15:0] rsp_errcode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lm_sreg_load_chk dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_pop(req_pop), .req_lock(req_lock), .req_sel(req_sel), .req_cpl(req_cpl),
        .gdt_limit(gdt_limit), .ldt_limit(ldt_limit), .desc_s(desc_s),
        .desc_type(desc_type), .desc_dpl(desc_dpl), .desc_present(desc_present),
        .rsp_valid(rsp_valid), .rsp_load(rsp_load), .rsp_fault(rsp_fault),
        .rsp_vector(rsp_vector), .rsp_errcode(rsp_errcode)
    );

    task automatic expect_of(output bit ld, output logic [7:0] vec,
                             output logic [15:0] err, output string rq);
        bit nul = (req_sel[15:2] == 14'd0);
        logic [1:0] rp = req_sel[1:0];
        logic [15:0] lim = req_sel[2] ? ldt_limit : gdt_limit;
        logic [15:0] top = {req_sel[15:3], 3'b111};
        ld = 0; vec = 0; err = 0;
        if (req_lock || req_seg == 3'd1 || req_seg > 3'd5 ||
            (req_pop && (req_seg == 3'd0 || req_seg == 3'd2 || req_seg == 3'd3))) begin
            vec = 8'd6; rq = "R2";
        end else if (nul) begin
            if (req_seg == 3'd2) begin
                rq = "R4";
                if (req_cpl == 2'd3 || rp != req_cpl) vec = 8'd13; else ld = 1;
            end else begin
                rq = "R3"; ld = 1;
            end
        end else if (top > lim) begin
            vec = 8'd13; err = req_sel & 16'hFFFC; rq = "R5";
        end else if (req_seg == 3'd2) begin
            rq = "R6";
            if (!(desc_s && !desc_type[3] && desc_type[1]) || rp != req_cpl || desc_dpl != req_cpl) begin
                vec = 8'd13; err = req_sel & 16'hFFFC;
            end else if (!desc_present) begin
                vec = 8'd12; err = req_sel & 16'hFFFC; rq = "R8";
            end else ld = 1;
        end else begin
            rq = "R7";
            if (!desc_s || (desc_type[3] && !desc_type[1])) begin
                vec = 8'd13; err = req_sel & 16'hFFFC;
            end else if (!(desc_type[3] && desc_type[2]) && rp > desc_dpl && req_cpl > desc_dpl) begin
                vec = 8'd13; err = req_sel & 16'hFFFC;
            end else if (!desc_present) begin
                rq = "R8";
                if (req_seg >= 3'd4) begin vec = 8'd11; err = req_sel & 16'hFFFC; end
                else ld = 1;
            end else ld = 1;
        end
    endtask

    task automatic check_now(input string tag);
        bit ld; logic [7:0] vec; logic [15:0] err; string rq;
        expect_of(ld, vec, err, rq);
        @(negedge clk);
        checks++;
        if (!rsp_valid || rsp_load != ld || rsp_fault != !ld || (!ld && rsp_vector != vec)) begin
            errors++;
            $display("FAIL %s/%s %s: got v=%0b ld=%0b f=%0b vec=%0d, expected ld=%0b vec=%0d",
                     rq, "R1", tag, rsp_valid, rsp_load, rsp_fault, rsp_vector, ld, vec);
        end
        checks++;
        if (!ld && rsp_errcode != err) begin
            errors++;
            $display("FAIL R10 %s: errcode got %h expected %h", tag, rsp_errcode, err);
        end
    endtask

    task automatic req(input logic [2:0] seg, input bit pop, input bit lock,
                       input logic [15:0] sel, input logic [1:0] cpl,
                       input bit s, input logic [3:0] typ, input logic [1:0] dpl,
                       input bit p, input string tag);
        req_valid = 1; req_seg = seg; req_pop = pop; req_lock = lock; req_sel = sel;
        req_cpl = cpl; desc_s = s; desc_type = typ; desc_dpl = dpl; desc_present = p;
        check_now(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1CE5EED));
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid || rsp_load || rsp_fault) begin
            errors++;
            $display("FAIL R1 reset: got v=%0b ld=%0b f=%0b expected all 0", rsp_valid, rsp_load, rsp_fault);
        end
        rst_n = 1;
        gdt_limit = 16'h003F; ldt_limit = 16'h000F;
        @(negedge clk);

        // R2: lock, CS, pop to SS/DS/ES, illegal code
        req(3'd4, 0, 1, 16'h0010, 2'd0, 1, 4'h2, 2'd0, 1, "R2 lock");
        req(3'd1, 0, 0, 16'h0008, 2'd0, 1, 4'hA, 2'd0, 1, "R2 mov cs");
        req(3'd1, 0, 0, 16'h0000, 2'd0, 1, 4'hA, 2'd0, 1, "R2 null cs");
        req(3'd2, 1, 0, 16'h0010, 2'd0, 1, 4'h2, 2'd0, 1, "R2 pop ss");
        req(3'd3, 1, 0, 16'h0003, 2'd0, 1, 4'h2, 2'd0, 1, "R2 pop ds");
        req(3'd7, 0, 0, 16'h0010, 2'd0, 1, 4'h2, 2'd0, 1, "R2 code 7");
        // R3: null into data regs, all four null values
        for (int i = 0; i < 4; i++)
            req(3'd3, 0, 0, 16'(i), 2'd3, 0, 4'h0, 2'd0, 0, "R3 null ds");
        req(3'd5, 1, 0, 16'h0002, 2'd3, 0, 4'h0, 2'd0, 0, "R3 null gs pop");
        // R4: null into SS
        req(3'd2, 0, 0, 16'h0003, 2'd3, 1, 4'h2, 2'd3, 1, "R4 cpl3");
        req(3'd2, 0, 0, 16'h0001, 2'd0, 1, 4'h2, 2'd0, 1, "R4 rpl mismatch");
        req(3'd2, 0, 0, 16'h0001, 2'd1, 1, 4'h2, 2'd0, 1, "R4 accepted");
        // R5: limit boundary in both tables; 0x0004 is LDT entry 0, not null
        req(3'd3, 0, 0, 16'h0038, 2'd0, 1, 4'h2, 2'd0, 1, "R5 gdt last fits");
        req(3'd3, 0, 0, 16'h0040, 2'd0, 1, 4'h2, 2'd0, 1, "R5 gdt over");
        req(3'd3, 0, 0, 16'h000F, 2'd3, 1, 4'h2, 2'd3, 1, "R5 ldt fits");
        req(3'd3, 0, 0, 16'h0017, 2'd3, 1, 4'h2, 2'd3, 1, "R5 ldt over");
        // R6
        req(3'd2, 0, 0, 16'h0010, 2'd0, 1, 4'h0, 2'd0, 1, "R6 ss readonly");
        req(3'd2, 0, 0, 16'h0012, 2'd2, 1, 4'h2, 2'd1, 1, "R6 ss dpl");
        req(3'd2, 0, 0, 16'h0012, 2'd2, 1, 4'h2, 2'd2, 1, "R6 ss ok");
        // R7
        req(3'd4, 0, 0, 16'h0010, 2'd0, 1, 4'h8, 2'd0, 1, "R7 exec-only");
        req(3'd4, 0, 0, 16'h0013, 2'd3, 1, 4'h2, 2'd0, 1, "R7 priv");
        req(3'd4, 0, 0, 16'h0013, 2'd3, 1, 4'hE, 2'd0, 1, "R7 conforming");
        req(3'd0, 0, 0, 16'h0013, 2'd0, 1, 4'h2, 2'd0, 1, "R7 rpl only");
        // R8
        req(3'd2, 0, 0, 16'h0010, 2'd0, 1, 4'h2, 2'd0, 0, "R8 ss np");
        req(3'd5, 0, 0, 16'h0010, 2'd0, 1, 4'h2, 2'd0, 0, "R8 gs np");
        req(3'd0, 0, 0, 16'h0010, 2'd0, 1, 4'h2, 2'd0, 0, "R8 es np");
        // R9: overlapping causes
        req(3'd2, 1, 0, 16'h0000, 2'd3, 0, 4'h0, 2'd0, 0, "R9 ud over null");
        req(3'd4, 0, 0, 16'h0048, 2'd3, 0, 4'h0, 2'd0, 0, "R9 limit over type");
        req(3'd4, 0, 0, 16'h0013, 2'd3, 1, 4'h2, 2'd0, 0, "R9 priv over np");

        // R1: idle cycle
        req_valid = 0;
        @(negedge clk);
        checks++;
        if (rsp_valid || rsp_load || rsp_fault) begin
            errors++;
            $display("FAIL R1 idle: got v=%0b ld=%0b f=%0b expected all 0", rsp_valid, rsp_load, rsp_fault);
        end

        for (int n = 0; n < 3000; n++) begin
            logic [15:0] sel;
            case ($urandom % 4)
                0: sel = 16'($urandom % 8);
                1: sel = 16'($urandom % 128);
                default: sel = 16'($urandom);
            endcase
            gdt_limit = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom % 128);
            ldt_limit = 16'($urandom % 64);
            req(3'($urandom % 8), ($urandom % 5) == 0, ($urandom % 16) == 0, sel,
                2'($urandom), 1'($urandom), 4'($urandom), 2'($urandom),
                ($urandom % 4) != 0, "random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule